// File: doc/BRIEF.md
# Interrupt claim and threshold selector

This block tracks the pending and in-service state of a set of level-driven interrupt sources and drives one registered interrupt line per target context. Each source carries a priority; each context has an enable mask over the sources and a threshold. A source counts for a context only if it is waiting, not already being serviced, unmasked for that context and strictly above the context's threshold. The context's line is high while any such source exists.

A handler claims work for one context at a time. The block answers with the lowest-numbered source that counts for that context, regardless of priority, moves it from pending to in-service, and keeps it masked until a completion names it. Source ID 0 is reserved as the "nothing to claim" answer. Priorities, masks and thresholds arrive as plain inputs; the register decoding and bus logic that hold them sit outside. Pending and in-service bits are kept in a flat vector with source n at bit n, which matches a layout of 32-bit words where source n sits in word n/32 at bit n%32.

Top module: `irq_claim_sel`

## Requirements
- R1: A source n (n >= 1) is eligible for context c only when its pending bit is set, its in-service bit is clear, bit n of context c's mask is 1, and its priority is strictly greater than c's threshold; an equal priority is not enough.
- R2: `ctx_irq[c]` is a register: after the clock edge it equals whether any source was eligible for c just before that edge, using the priorities, masks and thresholds present in that cycle.
- R3: A claim (`claim_req` high at an edge) sets `claim_vld` for the following cycle, and `claim_id` then holds the lowest-numbered source eligible for `claim_ctx`, even when a higher-numbered eligible source has a higher priority; `claim_vld` is low after any edge without a claim.
- R4: A successful claim clears the winner's pending bit and sets its in-service bit in the same edge, so the winner cannot be returned again until it is completed.
- R5: A claim that finds no eligible source returns `claim_id` 0 and leaves pending and in-service state unchanged.
- R6: A completion (`cmpl_req` high) with `cmpl_id` below `NSRC` clears that source's in-service bit.
- R7: A rising edge of `src_level[n]` sets pending bit n and a falling edge clears it; a bit cleared by a claim stays clear while the input stays high, until the input drops and rises again. A level change in the same cycle as a claim of that source wins over the claim's clear.
- R8: A completion with `cmpl_id` of `NSRC` or more changes no state.
- R9: A completion and a claim in the same cycle are both applied, the completion first, so the claim can return the source that is being completed.
- R10: Reset clears all pending, in-service and level history, and drives `ctx_irq`, `claim_vld` and `claim_id` to 0.
- R11: Source 0 is never pending, never claimed and never eligible, whatever its input, priority or mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NSRC | Level of each interrupt source |
| src_prio | input | NSRC*PW | Priority of source n in bits n*PW +: PW |
| ctx_en | input | NCTX*NSRC | Mask of context c in bits c*NSRC +: NSRC, bit n enables source n |
| ctx_thr | input | NCTX*PW | Threshold of context c in bits c*PW +: PW |
| claim_req | input | 1 | Claim strobe |
| claim_ctx | input | CW | Context that claims |
| cmpl_req | input | 1 | Completion strobe |
| cmpl_id | input | IDW | Source being completed |
| ctx_irq | output | NCTX | Registered interrupt line per context |
| claim_vld | output | 1 | Claim answer present this cycle |
| claim_id | output | IDW | Claimed source, 0 when none |

## Verification
The bench aims at the cases where a selector is easy to get subtly wrong: a low-priority source beating a high-priority one by its lower ID, a threshold equal to the priority, a second claim while the first winner is still in service, and a completion that shares its cycle with a claim of the same source. A design that sorted by priority would return the higher-priority source; one that compared with greater-or-equal would leave the line raised at the equal threshold; one that ran the completion after the scan would answer 0 in the shared cycle. It also holds a source input high across its claim and completion to catch a design that re-pends from the level rather than from its edges, and sends completion IDs past the last source that a design without a range check would let wrap onto a real source.

// File: rtl/irq_claim_sel.sv
module irq_claim_sel #(
  parameter int NSRC = 40,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_level,
  input  logic [NSRC*PW-1:0]   src_prio,
  input  logic [NCTX*NSRC-1:0] ctx_en,
  input  logic [NCTX*PW-1:0]   ctx_thr,
  input  logic                 claim_req,
  input  logic [CW-1:0]        claim_ctx,
  input  logic                 cmpl_req,
  input  logic [IDW-1:0]       cmpl_id,
  output logic [NCTX-1:0]      ctx_irq,
  output logic                 claim_vld,
  output logic [IDW-1:0]       claim_id
);

  localparam logic [NSRC-1:0] LIVE = ~(NSRC'(1));

  logic [NSRC-1:0] pend_q, clm_q, lvl_q;
  logic [NSRC-1:0] pend_d, clm_d, clm_eff, cand, done_mask;
  logic [NCTX-1:0][NSRC-1:0] above;
  logic [NCTX-1:0] any_elig;
  logic [IDW-1:0] win;
  logic hit, claim_ok;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    for (genvar n = 0; n < NSRC; n++) begin : g_src
      assign above[c][n] = src_prio[n*PW +: PW] > ctx_thr[c*PW +: PW];
    end
    assign any_elig[c] = |(pend_q & ~clm_q & ctx_en[c*NSRC +: NSRC] & above[c] & LIVE);
  end

  assign claim_ok = claim_req && (32'(claim_ctx) < NCTX);

  always_comb begin
    done_mask = '0;
    for (int n = 0; n < NSRC; n++)
      if (cmpl_req && 32'(cmpl_id) == n) done_mask[n] = 1'b1;
    clm_eff = clm_q & ~done_mask;

    cand = '0;
    for (int c = 0; c < NCTX; c++)
      if (claim_ok && 32'(claim_ctx) == c)
        cand = pend_q & ~clm_eff & ctx_en[c*NSRC +: NSRC] & above[c] & LIVE;

    win = '0;
    for (int n = NSRC - 1; n >= 1; n--)
      if (cand[n]) win = IDW'(n);
    hit = |cand;

    pend_d = pend_q;
    clm_d  = clm_eff;
    for (int n = 1; n < NSRC; n++) begin
      if (hit && 32'(win) == n) begin
        pend_d[n] = 1'b0;
        clm_d[n]  = 1'b1;
      end
      if (src_level[n] != lvl_q[n]) pend_d[n] = src_level[n];
    end
    pend_d[0] = 1'b0;
    clm_d[0]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      clm_q     <= '0;
      lvl_q     <= '0;
      ctx_irq   <= '0;
      claim_vld <= 1'b0;
      claim_id  <= '0;
    end else begin
      pend_q    <= pend_d;
      clm_q     <= clm_d;
      lvl_q     <= src_level;
      ctx_irq   <= any_elig;
      claim_vld <= claim_req;
      if (claim_req) claim_id <= win;
    end
  end

  // R4: the winner is in service and no longer pending after the edge
  a_r4_claim_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && src_level[win] == lvl_q[win]) |=> (clm_q[$past(win)] && !pend_q[$past(win)]));

  // R5: an empty claim leaves in-service state alone
  a_r5_empty_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && !hit && !cmpl_req) |=> $stable(clm_q));

  // R6: a valid completion releases its source unless it is reclaimed at once
  a_r6_cmpl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_req && 32'(cmpl_id) < NSRC && !(hit && win == cmpl_id)) |=> !clm_q[$past(cmpl_id)]);

  // R8: an out-of-range completion does nothing
  a_r8_bad_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_req && 32'(cmpl_id) >= NSRC && !claim_req) |=> $stable(clm_q));

  // R11: source 0 stays inert
  a_r11_src0_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q[0] && !clm_q[0]));

  // R3: answers always name a real source or 0
  a_r3_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    claim_vld |-> (32'(claim_id) < NSRC));

endmodule

// File: tb/irq_claim_sel_tb.sv
`timescale 1ns/1ps
module irq_claim_sel_tb_top;
  localparam int NSRC = 40, NCTX = 2, PW = 3, IDW = 6, CW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0]      src_level = '0;
  logic [NSRC*PW-1:0]   src_prio  = '0;
  logic [NCTX*NSRC-1:0] ctx_en    = '0;
  logic [NCTX*PW-1:0]   ctx_thr   = '0;
  logic claim_req = 1'b0, cmpl_req = 1'b0;
  logic [CW-1:0]  claim_ctx = '0;
  logic [IDW-1:0] cmpl_id = '0;
  logic [NCTX-1:0] ctx_irq;
  logic claim_vld;
  logic [IDW-1:0] claim_id;

  irq_claim_sel #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .src_prio(src_prio),
    .ctx_en(ctx_en), .ctx_thr(ctx_thr), .claim_req(claim_req), .claim_ctx(claim_ctx),
    .cmpl_req(cmpl_req), .cmpl_id(cmpl_id), .ctx_irq(ctx_irq),
    .claim_vld(claim_vld), .claim_id(claim_id));

  always #2.5 clk = ~clk;

  bit m_pend[NSRC], m_clm[NSRC], m_lvl[NSRC];
  int n_run = 0, n_fail = 0, got_id = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit counts(int c, int n, bit busy);
    return n != 0 && m_pend[n] && !busy && ctx_en[c*NSRC + n] &&
           (src_prio[n*PW +: PW] > ctx_thr[c*PW +: PW]);
  endfunction

  task automatic do_cycle();
    bit exp_irq[NCTX];
    bit busy[NSRC];
    int win = 0;
    bit was_claim = claim_req;
    for (int c = 0; c < NCTX; c++) begin
      exp_irq[c] = 0;
      for (int n = 0; n < NSRC; n++) if (counts(c, n, m_clm[n])) exp_irq[c] = 1;
    end
    for (int n = 0; n < NSRC; n++)
      busy[n] = m_clm[n] && !(cmpl_req && int'(cmpl_id) == n);
    if (claim_req)
      for (int n = NSRC - 1; n >= 1; n--)
        if (counts(int'(claim_ctx), n, busy[n])) win = n;
    if (win != 0) begin
      m_pend[win] = 0;
      busy[win] = 1;
    end
    for (int n = 1; n < NSRC; n++) begin
      if (src_level[n] != m_lvl[n]) m_pend[n] = src_level[n];
      m_clm[n] = busy[n];
    end
    for (int n = 0; n < NSRC; n++) m_lvl[n] = src_level[n];
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCTX; c++)
      check(ctx_irq[c] == exp_irq[c], "R2 irq", ctx_irq[c], exp_irq[c]);
    check(claim_vld == was_claim, "R3 vld", claim_vld, was_claim);
    if (was_claim) begin
      check(int'(claim_id) == win, "R3 id", claim_id, win);
      got_id = claim_id;
    end
    claim_req = 0;
    cmpl_req = 0;
  endtask

  task automatic claim(input int c);
    claim_req = 1; claim_ctx = CW'(c);
    do_cycle();
  endtask

  task automatic complete(input int id);
    cmpl_req = 1; cmpl_id = IDW'(id);
    do_cycle();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) do_cycle();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(ctx_irq == 0 && claim_vld == 0 && claim_id == 0, "R10 reset", ctx_irq, 0);
    rst_n = 1;
    idle(1);
    check(ctx_irq == 0 && claim_vld == 0, "R10 after reset", ctx_irq, 0);

    src_prio[5*PW +: PW] = 3'd1;
    src_prio[9*PW +: PW] = 3'd7;
    src_prio[3*PW +: PW] = 3'd2;
    src_prio[0*PW +: PW] = 3'd7;
    ctx_en[0*NSRC + 5] = 1; ctx_en[0*NSRC + 9] = 1; ctx_en[0*NSRC + 0] = 1;
    ctx_en[1*NSRC + 3] = 1; ctx_en[1*NSRC + 0] = 1;
    src_level[5] = 1; src_level[9] = 1; src_level[3] = 1; src_level[0] = 1;
    idle(2);
    check(ctx_irq[0] == 1, "R2 line up", ctx_irq[0], 1);
    claim(0);
    check(got_id == 5, "R3 lowest id beats priority", got_id, 5);
    claim(0);
    check(got_id == 9, "R4 claimed source masked", got_id, 9);
    claim(0);
    check(got_id == 0, "R5 empty claim", got_id, 0);
    idle(1);
    check(ctx_irq[0] == 0, "R5 line low", ctx_irq[0], 1'b0);
    claim(1);
    check(got_id == 3, "R11 ctx1 claim", got_id, 3);
    claim(1);
    check(got_id == 0, "R11 source 0 never returned", got_id, 0);

    complete(5);
    claim(0);
    check(got_id == 0, "R7 held level does not re-pend", got_id, 0);
    src_level[5] = 0; idle(1);
    src_level[5] = 1; idle(1);
    claim(0);
    check(got_id == 5, "R6 R7 re-raised after completion", got_id, 5);

    src_level[9] = 0; idle(1);
    src_level[9] = 1; idle(1);
    complete(63);
    claim(0);
    check(got_id == 0, "R8 out-of-range completion ignored", got_id, 0);
    cmpl_req = 1; cmpl_id = 6'd9;
    claim(0);
    check(got_id == 9, "R9 completion before claim", got_id, 9);

    complete(9);
    src_level[9] = 0; idle(1);
    src_level[9] = 1;
    ctx_thr[0*PW +: PW] = 3'd7;
    idle(2);
    check(ctx_irq[0] == 0, "R1 equal threshold line", ctx_irq[0], 0);
    claim(0);
    check(got_id == 0, "R1 equal threshold blocks", got_id, 0);
    ctx_thr[0*PW +: PW] = 3'd6;
    claim(0);
    check(got_id == 9, "R1 above threshold", got_id, 9);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 3 == 0) src_level[$urandom % NSRC] ^= 1'b1;
      if ($urandom % 16 == 0) src_prio[($urandom % NSRC)*PW +: PW] = PW'($urandom);
      if ($urandom % 16 == 0) ctx_en[$urandom % (NCTX*NSRC)] ^= 1'b1;
      if ($urandom % 32 == 0) ctx_thr[($urandom % NCTX)*PW +: PW] = PW'($urandom % 4);
      if ($urandom % 3 == 0) begin claim_req = 1; claim_ctx = CW'($urandom % NCTX); end
      if ($urandom % 4 == 0) begin
        cmpl_req = 1;
        cmpl_id = ($urandom % 8 == 0) ? IDW'(NSRC + $urandom % (64 - NSRC)) : IDW'($urandom % NSRC);
      end
      do_cycle();
    end
    finished = 1;
    summary();
  end
endmodule